// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits on the controller side of an asynchronous DRAM with row-refresh needs. It drives the row strobe, the column strobe and the write strobe during the periods when the array is being refreshed rather than accessed. After reset it holds every strobe inactive for a power-up pause. It then runs a counted set of CAS-before-RAS refresh cycles as the initialization sequence and raises its ready flag. From then on it keeps the rows alive with periodic CAS-before-RAS refresh. Each refresh takes the bus only when the normal-access arbiter grants it.

A self-refresh request moves the DRAM into self-refresh once the bus is granted. The strobes stay low for at least a minimum time and for as long as the request is held. When the request is released, the block raises both strobes for an exit hold time. It then runs a burst of back-to-back refreshes that covers every row, and only after that does ready return. The write strobe stays high at all times, so that no refresh cycle can be taken as a test-mode entry. Every duration is a parameter given in clock cycles. The periodic interval is the selected refresh period (standard or low-power) divided by the row count.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_n is low, ras_n, cas_n and we_n are high, ready is low and busy is high.
- R2: After reset release all strobes stay high for PAUSE_CYC cycles; the first cas_n fall is seen in cycle PAUSE_CYC counted from the first clock edge after release.
- R3: After the pause exactly INIT_CYCLES refresh cycles run, and ready rises in cycle PAUSE_CYC + T_CSR + INIT_CYCLES*(RAS_LOW + PRE_CYC), where RAS_LOW = max(T_RAS, T_CHR) and PRE_CYC = max(T_RP, T_CSR).
- R4: Every ras_n fall is preceded by at least T_CSR cycles of cas_n low, cas_n stays low for as long as ras_n is low, a refresh holds ras_n low for exactly RAS_LOW cycles, and we_n is never low.
- R5: Between any two ras_n low periods, ras_n stays high for at least T_RP cycles.
- R6: Within the initialization run and within the post-self-refresh burst, cas_n stays low across the precharge, so only the first refresh of each run follows a fresh cas_n fall.
- R7: Periodic refreshes are spaced INTERVAL = PERIOD/ROWS cycles apart, where PERIOD is PERIOD_LP_CYC when LOW_POWER is 1 and PERIOD_STD_CYC otherwise; the first ras_n fall lands INTERVAL + T_CSR + 1 cycles after ready rises.
- R8: A periodic refresh starts only while gnt is high. Requests that arrive while gnt is low accumulate up to PEND_MAX, and are served back to back once gnt returns. Requests beyond PEND_MAX are dropped.
- R9: When sr_req and gnt are both high in idle, ready falls, cas_n falls, and ras_n follows T_CSR cycles later. Both stay low for at least SR_MIN_CYC cycles and for as long as sr_req stays high, so a request released early gives exactly SR_MIN_CYC cycles.
- R10: On self-refresh exit both strobes are high for EXIT_CYC = max(T_CHS, T_RP) cycles. Then ROWS refresh cycles run, and ready returns EXIT_CYC + T_CSR + ROWS*(RAS_LOW + PRE_CYC) cycles after ras_n rises.
- R11: busy is low only when the sequencer is idle with no pending refresh and no sr_req; a pending refresh held off by a low gnt keeps busy high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, applied once the supply is stable |
| sr_req | input | 1 | Request to enter and stay in self-refresh |
| gnt | input | 1 | Bus grant from the normal-access arbiter |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| busy | output | 1 | Sequencer wants or holds the DRAM bus |
| ready | output | 1 | Normal accesses may be granted |

## Verification
The bench uses ROWS = 16, a 50-cycle pause, eight initialization cycles, and periods of 3200 and 6400 cycles, which give refresh intervals of 200 and 400 cycles. It also uses a 40-cycle self-refresh minimum and single-digit strobe timings. With these values, the whole initialization run, several periodic intervals, a pending counter pushed past saturation, and two complete self-refresh entry, exit and burst sequences fit into a few thousand cycles. A second instance with LOW_POWER set shows that the longer period takes effect.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_CSR,
    ST_RASLO,
    ST_PRE,
    ST_IDLE,
    ST_SR_CSR,
    ST_SR_HOLD,
    ST_SR_EXIT
  } seq_st_e;

  typedef enum logic [1:0] {
    K_INIT,
    K_PERIODIC,
    K_BURST
  } ref_kind_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    return max2(1, $clog2(n + 1));
  endfunction

  // cycles between periodic refreshes; never below one
  function automatic int unsigned refresh_interval(input int unsigned period_cyc,
                                                   input int unsigned rows);
    return max2(1, period_cyc / rows);
  endfunction

  // row-strobe low time must cover both the active time and the CAS hold
  function automatic int unsigned ras_low_cyc(input int unsigned t_ras, input int unsigned t_chr);
    return max2(max2(t_ras, t_chr), 1);
  endfunction

endpackage

// File: rtl/seq_downcount.sv
module seq_downcount #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= W'(RST_VAL);
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int unsigned INTERVAL = 1024,
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic pending
);
  import dram_seq_pkg::*;

  localparam int unsigned CW = width_for(INTERVAL);
  localparam int unsigned PW = width_for(PEND_MAX);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick = run && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      pend <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && !take && pend != PW'(PEND_MAX))
        pend <= pend + 1'b1;
      else if (take && !tick && pend != '0)
        pend <= pend - 1'b1;
    end
  end

  assign pending = (pend != '0);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned PAUSE_CYC      = 20000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned ROWS           = 1024,
  parameter int unsigned PERIOD_STD_CYC = 1600000,
  parameter int unsigned PERIOD_LP_CYC  = 12800000,
  parameter bit          LOW_POWER      = 1'b0,
  parameter int unsigned T_CSR          = 1,
  parameter int unsigned T_CHR          = 2,
  parameter int unsigned T_RAS          = 6,
  parameter int unsigned T_RP           = 5,
  parameter int unsigned SR_MIN_CYC     = 10000,
  parameter int unsigned T_CHS          = 5,
  parameter int unsigned PEND_MAX       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic ready
);
  import dram_seq_pkg::*;

  localparam int unsigned PERIOD   = LOW_POWER ? PERIOD_LP_CYC : PERIOD_STD_CYC;
  localparam int unsigned INTERVAL = refresh_interval(PERIOD, ROWS);
  localparam int unsigned RAS_LOW  = ras_low_cyc(T_RAS, T_CHR);
  localparam int unsigned PRE_CYC  = max2(max2(T_RP, T_CSR), 1);
  localparam int unsigned CSR_CYC  = max2(T_CSR, 1);
  localparam int unsigned EXIT_CYC = max2(max2(T_CHS, T_RP), 1);
  localparam int unsigned SR_CYC   = max2(SR_MIN_CYC, 1);
  localparam int unsigned PAUSE_C  = max2(PAUSE_CYC, 1);
  localparam int unsigned MAXDUR   = max2(max2(PAUSE_C, SR_CYC),
                                          max2(max2(CSR_CYC, RAS_LOW), max2(PRE_CYC, EXIT_CYC)));
  localparam int unsigned TW       = width_for(MAXDUR);
  localparam int unsigned LW       = width_for(max2(ROWS, INIT_CYCLES));

  seq_st_e   st, nst;
  ref_kind_e kind, nkind;
  logic      ready_q, set_ready, clr_ready;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic          left_load, left_dec, left_zero;
  logic [LW-1:0] left_val, left_cnt;
  logic          pending, take;

  // named events brought out for the checker
  logic at_idle, in_self, hold_cas;
  assign at_idle  = (st == ST_IDLE);
  assign in_self  = (st == ST_SR_HOLD);
  assign hold_cas = (kind != K_PERIODIC) && !left_zero;

  seq_downcount #(.W(TW), .RST_VAL(PAUSE_C - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .dec(1'b1),
    .load_val(tmr_val), .cnt(tmr_cnt), .zero(tmr_zero)
  );

  seq_downcount #(.W(LW), .RST_VAL(0)) u_left (
    .clk(clk), .rst_n(rst_n), .load(left_load), .dec(left_dec),
    .load_val(left_val), .cnt(left_cnt), .zero(left_zero)
  );

  refresh_pacer #(.INTERVAL(INTERVAL), .PEND_MAX(PEND_MAX)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(ready_q), .take(take), .pending(pending)
  );

  always_comb begin
    nst       = st;
    nkind     = kind;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    left_load = 1'b0;
    left_val  = '0;
    left_dec  = 1'b0;
    take      = 1'b0;
    set_ready = 1'b0;
    clr_ready = 1'b0;
    unique case (st)
      ST_PAUSE: if (tmr_zero) begin
        nst = ST_CSR; nkind = K_INIT;
        tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        left_load = 1'b1; left_val = LW'(INIT_CYCLES - 1);
      end
      ST_CSR: if (tmr_zero) begin
        nst = ST_RASLO; tmr_load = 1'b1; tmr_val = TW'(RAS_LOW - 1);
      end
      ST_RASLO: if (tmr_zero) begin
        nst = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(PRE_CYC - 1);
      end
      ST_PRE: if (tmr_zero) begin
        if (!left_zero) begin
          nst = ST_RASLO; left_dec = 1'b1;
          tmr_load = 1'b1; tmr_val = TW'(RAS_LOW - 1);
        end else begin
          nst = ST_IDLE;
          set_ready = (kind != K_PERIODIC);
        end
      end
      ST_IDLE: if (gnt && sr_req) begin
        nst = ST_SR_CSR; clr_ready = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
      end else if (gnt && pending) begin
        nst = ST_CSR; nkind = K_PERIODIC; take = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        left_load = 1'b1; left_val = '0;
      end
      ST_SR_CSR: if (tmr_zero) begin
        nst = ST_SR_HOLD; tmr_load = 1'b1; tmr_val = TW'(SR_CYC - 1);
      end
      ST_SR_HOLD: if (tmr_zero && !sr_req) begin
        nst = ST_SR_EXIT; tmr_load = 1'b1; tmr_val = TW'(EXIT_CYC - 1);
      end
      ST_SR_EXIT: if (tmr_zero) begin
        nst = ST_CSR; nkind = K_BURST;
        tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        left_load = 1'b1; left_val = LW'(ROWS - 1);
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_PAUSE;
      kind    <= K_INIT;
      ready_q <= 1'b0;
    end else begin
      st   <= nst;
      kind <= nkind;
      if (set_ready)      ready_q <= 1'b1;
      else if (clr_ready) ready_q <= 1'b0;
    end
  end

  assign ras_n = !(st == ST_RASLO || st == ST_SR_HOLD);
  assign cas_n = !(st == ST_CSR || st == ST_RASLO || st == ST_SR_CSR ||
                   st == ST_SR_HOLD || (st == ST_PRE && hold_cas));
  assign we_n  = 1'b1;
  assign busy  = !(at_idle && !pending && !sr_req);
  assign ready = ready_q;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int unsigned PAUSE_CYC  = 20000,
  parameter int unsigned T_RP       = 5,
  parameter int unsigned RAS_LOW    = 6,
  parameter int unsigned SR_MIN_CYC = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic sr_req,
  input logic gnt,
  input logic ras_n,
  input logic cas_n,
  input logic busy,
  input logic ready,
  input logic at_idle,
  input logic in_self
);

  logic [31:0] cyc, hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= '0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1;
      hi_cnt <= ras_n ? ((hi_cnt != 32'hFFFF_FFFF) ? hi_cnt + 1 : hi_cnt) : '0;
      lo_cnt <= ras_n ? '0 : ((lo_cnt != 32'hFFFF_FFFF) ? lo_cnt + 1 : lo_cnt);
    end
  end

  a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < PAUSE_CYC) |-> (ras_n && cas_n));

  a_r3_ready_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_n && cas_n));

  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && !$past(in_self)) |-> (lo_cnt == RAS_LOW));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= T_RP));

  a_r8_grant_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && $past(at_idle)) |-> $past(gnt));

  a_r9_self_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(in_self)) |-> (lo_cnt >= SR_MIN_CYC));

  a_r9_self_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_self |-> !ready);

  a_r11_busy_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && !sr_req));

endmodule

bind dram_refresh_seq dram_seq_chk #(
  .PAUSE_CYC(PAUSE_C), .T_RP(T_RP), .RAS_LOW(RAS_LOW), .SR_MIN_CYC(SR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .gnt(gnt), .ras_n(ras_n),
  .cas_n(cas_n), .busy(busy), .ready(ready), .at_idle(at_idle), .in_self(in_self)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

  localparam int PAUSE = 50, INIT = 8, ROWS = 16;
  localparam int PSTD = 3200, PLP = 6400;
  localparam int T_CSR = 2, T_CHR = 3, T_RAS = 4, T_RP = 3, SR_MIN = 40, T_CHS = 5, PMAX = 4;
  // bench restatement of the derived timings
  localparam int RAS_LOW = (T_RAS > T_CHR) ? T_RAS : T_CHR;
  localparam int PRE     = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int EXIT    = (T_CHS > T_RP) ? T_CHS : T_RP;
  localparam int IVL     = PSTD / ROWS;
  localparam int IVL_LP  = PLP / ROWS;

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, gnt = 1'b1;
  logic ras_n, cas_n, we_n, busy, ready;
  logic lp_ras_n, lp_cas_n, lp_we_n, lp_busy, lp_ready;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .ROWS(ROWS), .PERIOD_STD_CYC(PSTD),
    .PERIOD_LP_CYC(PLP), .LOW_POWER(1'b0), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS),
    .T_RP(T_RP), .SR_MIN_CYC(SR_MIN), .T_CHS(T_CHS), .PEND_MAX(PMAX)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .gnt(gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy), .ready(ready)
  );

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .ROWS(ROWS), .PERIOD_STD_CYC(PSTD),
    .PERIOD_LP_CYC(PLP), .LOW_POWER(1'b1), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS),
    .T_RP(T_RP), .SR_MIN_CYC(SR_MIN), .T_CHS(T_CHS), .PEND_MAX(PMAX)
  ) i_dram_refresh_seq_lp (
    .clk(clk), .rst_n(rst_n), .sr_req(1'b0), .gnt(1'b1),
    .ras_n(lp_ras_n), .cas_n(lp_cas_n), .we_n(lp_we_n), .busy(lp_busy), .ready(lp_ready)
  );

  // ---------------- monitor (samples at the falling edge) ----------------
  int cyc, lo_run, hi_run, cas_lo_run, cas_hi_run;
  int nfall = 0, nfresh = 0, bad_setup = 0, bad_pre = 0, bad_hold = 0, bad_we = 0;
  int last_fall = 0, prev_fall = 0, last_lo = 0, last_cas_hi = 0, ready_rise = 0, first_cas = -1;
  int lp_nfall = 0, lp_last = 0, lp_prev = 0;
  bit p_ras, p_cas, p_rdy, fresh, lp_p_ras;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; lo_run = 0; hi_run = 0; cas_lo_run = 0; cas_hi_run = 0;
      p_ras = 1; p_cas = 1; p_rdy = 0; fresh = 0; lp_p_ras = 1;
    end else begin
      cyc++;
      if (p_ras && !ras_n) begin
        nfall++;
        if (cas_lo_run < T_CSR) bad_setup++;
        if (nfall > 1 && hi_run < T_RP) bad_pre++;
        if (fresh) nfresh++;
        fresh = 0; prev_fall = last_fall; last_fall = cyc;
      end
      if (!p_ras && ras_n) last_lo = lo_run;
      if (p_cas && !cas_n) begin
        fresh = 1; last_cas_hi = cas_hi_run;
        if (first_cas < 0) first_cas = cyc;
      end
      if (ready && !p_rdy) ready_rise = cyc;
      if (!ras_n && cas_n) bad_hold++;
      if (!we_n) bad_we++;
      lo_run     = ras_n ? 0 : lo_run + 1;
      hi_run     = ras_n ? hi_run + 1 : 0;
      cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_rdy = ready;
      if (lp_p_ras && !lp_ras_n) begin lp_nfall++; lp_prev = lp_last; lp_last = cyc; end
      lp_p_ras = lp_ras_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp, input bit ok);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_ras(input bit lvl, input int limit);
    for (int i = 0; i < limit && ras_n != lvl; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_fall(input int limit);
    int n0 = nfall;
    for (int i = 0; i < limit && nfall == n0; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !ready; i++) begin @(negedge clk); #1; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    step(3);
    chk("R1 strobes high in reset", {ras_n, cas_n, we_n}, 7, ras_n && cas_n && we_n);
    chk("R1 ready low busy high in reset", {ready, busy}, 1, !ready && busy);
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    wait_ready(PAUSE + 200);
    chk("R2 first cas fall cycle", first_cas, PAUSE, first_cas == PAUSE);
    chk("R3 init refresh count", nfall, INIT, nfall == INIT);
    chk("R3 ready rise cycle", ready_rise, PAUSE + T_CSR + INIT * (RAS_LOW + PRE),
        ready_rise == PAUSE + T_CSR + INIT * (RAS_LOW + PRE));
    chk("R6 one fresh cas fall in init run", nfresh, 1, nfresh == 1);
    chk("R4 ras low width", last_lo, RAS_LOW, last_lo == RAS_LOW);
  endtask

  task automatic t_periodic();
    int r = ready_rise;
    wait_fall(IVL + 50);
    chk("R7 first periodic fall", last_fall, r + IVL + T_CSR + 1, last_fall == r + IVL + T_CSR + 1);
    wait_fall(IVL + 50);
    chk("R7 periodic interval", last_fall - prev_fall, IVL, last_fall - prev_fall == IVL);
    chk("R5 precharge never short", bad_pre, 0, bad_pre == 0);
    step(20);
    chk("R11 busy low in idle", busy, 0, !busy);
  endtask

  task automatic t_grant_hold(input int ivls, input int expect_n, input string tag);
    int n0;
    wait_fall(IVL + 50);
    step(1);
    gnt = 1'b0;
    n0 = nfall;
    step(ivls * IVL + IVL / 2 - 1);
    chk({tag, " no refresh without gnt"}, nfall - n0, 0, nfall == n0);
    chk({"R11 busy while pending ", tag}, busy, 1, busy);
    gnt = 1'b1;
    step(60);
    chk({tag, " pending served"}, nfall - n0, expect_n, nfall - n0 == expect_n);
  endtask

  task automatic t_self(input int hold, input int exp_lo, input string tag);
    int n0, f0, rise;
    wait_fall(IVL + 50);
    step(20);
    sr_req = 1'b1;
    step(2);
    chk({"R9 ready drops on entry ", tag}, ready, 0, !ready);
    wait_ras(1'b0, 20);
    step(hold);
    sr_req = 1'b0;
    wait_ras(1'b1, SR_MIN + hold + 10);
    rise = cyc;
    chk({"R9 self-refresh low time ", tag}, last_lo, exp_lo, last_lo == exp_lo || last_lo == exp_lo + 1);
    n0 = nfall; f0 = nfresh;
    wait_ready(ROWS * (RAS_LOW + PRE) + 100);
    chk({"R10 exit hold ", tag}, last_cas_hi, EXIT, last_cas_hi == EXIT);
    chk({"R10 burst length ", tag}, nfall - n0, ROWS, nfall - n0 == ROWS);
    chk({"R6 one fresh cas fall in burst ", tag}, nfresh - f0, 1, nfresh - f0 == 1);
    chk({"R10 ready return cycle ", tag}, ready_rise - rise, EXIT + T_CSR + ROWS * (RAS_LOW + PRE),
        ready_rise - rise == EXIT + T_CSR + ROWS * (RAS_LOW + PRE));
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    t_powerup();
    t_periodic();
    t_grant_hold(3, 3, "R8 held grant");
    t_grant_hold(6, PMAX, "R8 saturation");
    t_self(5, SR_MIN, "short");
    t_self(SR_MIN + 30, SR_MIN + 30, "long");
    step(2 * IVL_LP);
    chk("R7 low-power interval", lp_last - lp_prev, IVL_LP, lp_nfall > INIT + 1 && lp_last - lp_prev == IVL_LP);
    chk("R4 cas setup before every ras fall", bad_setup, 0, bad_setup == 0);
    chk("R4 cas held during ras low", bad_hold, 0, bad_hold == 0);
    chk("R4 write strobe never low", bad_we, 0, bad_we == 0);
    chk("R5 precharge overall", bad_pre, 0, bad_pre == 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule